// File: doc/BRIEF.md
# Two-Dice Craps Game Controller

This block plays a craps-style game with two dice. A press-and-hold button spins a pair of counters that stand for the dice. Each counter shows a face from 1 to 6, so the pair always sums to between 2 and 12. When the button is let go, the counters stop and the sum is judged.

The first throw of a game is decided right away in two cases. Seven or eleven wins. Two, three or twelve loses. Any other sum becomes the point: it is stored, and play continues. On every later throw, rolling the point wins, rolling a seven loses, and anything else asks for another throw.

A decided game holds its light until reset. Reset clears the dice to 1/1 and begins a new game. The dice behave as one 36-state sequence. The first die steps on every rolling cycle and wraps from 6 to 1, and the second die steps each time the first one wraps. The faces shown therefore depend only on how many cycles the controller spends rolling.

Top module: `dice_game`

## Requirements
- R1: While reset is high at a clock edge, after that edge both dice show 1 and both the win light and the lose light are off.
- R2: Each press of the button that is held for N sampled clock cycles advances the dice by exactly N steps. On each step the first die goes from face f to f+1, and from 6 back to 1. The second die steps in the same way, but only on steps where the first die wraps from 6 to 1. When no press is in progress, the dice hold their values.
- R3: On the first throw of a game, a sum of 7 or 11 turns on the win light.
- R4: On the first throw of a game, a sum of 2, 3 or 12 turns on the lose light.
- R5: On the first throw of a game, any other sum leaves both lights off, stores the sum as the point, and the game continues.
- R6: On a later throw, a sum equal to the stored point turns on the win light.
- R7: On a later throw, a sum of 7 turns on the lose light.
- R8: On a later throw, any sum other than the point or 7 leaves both lights off, and the game continues.
- R9: A throw is judged only after the button is released. While it is held, both lights stay off.
- R10: Once a light is on, it stays on, and further presses change neither the dice nor the lights until reset.
- R11: Reset in the middle of a game discards the point. The next throw is judged under the first-throw rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts a new game |
| roll_btn | input | 1 | Roll button, high while held (already debounced) |
| die_a | output | DIE_W (3) | Face of the first die, 1..FACES |
| die_b | output | DIE_W (3) | Face of the second die, 1..FACES |
| win_led | output | 1 | Win light |
| lose_led | output | 1 | Lose light |

## Verification
The hardest outcomes to reach from the ports are on later throws. A win by matching the point needs one chosen sum in the first throw and then a repeat of that same sum before any seven turns up. The bench exploits the fact that the dice pair is a deterministic base-36 counter: the hold length of each press selects its outcome exactly. It sweeps all 36 first-throw faces. After each throw that sets a point, it re-rolls with a step of 5, which is coprime to 36, so the walk is bound to hit either the point or a seven. A mid-game reset followed by a first-throw seven tells apart the two rule sets.

// File: rtl/dice_pkg.sv
package dice_pkg;

    typedef enum logic [2:0] {
        ST_FIRST_WAIT,
        ST_FIRST_ROLL,
        ST_FIRST_EVAL,
        ST_NEXT_WAIT,
        ST_NEXT_ROLL,
        ST_NEXT_EVAL,
        ST_WON,
        ST_LOST
    } game_state_e;

    // Decoded facts about the current sum
    typedef struct packed {
        logic sum7;     // sum is seven
        logic natural;  // sum is seven or eleven
        logic craps;    // sum is two, three or twelve
        logic match;    // sum equals stored point
    } roll_flags_t;

    // Controller commands
    typedef struct packed {
        logic roll;
        logic save_point;
        logic win;
        logic lose;
    } ctrl_out_t;

    localparam int unsigned SUM_TWO    = 2;
    localparam int unsigned SUM_THREE  = 3;
    localparam int unsigned SUM_SEVEN  = 7;
    localparam int unsigned SUM_ELEVEN = 11;
    localparam int unsigned SUM_TWELVE = 12;

    function automatic logic is_natural(input int unsigned s);
        return (s == SUM_SEVEN) || (s == SUM_ELEVEN);
    endfunction

    function automatic logic is_craps(input int unsigned s);
        return (s == SUM_TWO) || (s == SUM_THREE) || (s == SUM_TWELVE);
    endfunction

endpackage

// File: rtl/dice_pair.sv
module dice_pair #(
    parameter int unsigned FACES    = 6,
    parameter int unsigned DIE_W    = $clog2(FACES + 1),
    parameter int unsigned NUM_DICE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll,
    output logic [DIE_W-1:0] die_a,
    output logic [DIE_W-1:0] die_b
);
    localparam logic [DIE_W-1:0] TOP_FACE = DIE_W'(FACES);
    localparam logic [DIE_W-1:0] LOW_FACE = DIE_W'(1);

    logic [DIE_W-1:0] face [NUM_DICE];
    logic [NUM_DICE-1:0] step;

    assign step[0] = roll;

    for (genvar g = 0; g < NUM_DICE; g++) begin : g_die
        always_ff @(posedge clk) begin
            if (rst) begin
                face[g] <= LOW_FACE;
            end else if (step[g]) begin
                face[g] <= (face[g] == TOP_FACE) ? LOW_FACE : face[g] + LOW_FACE;
            end
        end
        if (g < NUM_DICE - 1) begin : g_carry
            assign step[g+1] = step[g] && (face[g] == TOP_FACE);
        end
    end

    assign die_a = face[0];
    assign die_b = face[1];
endmodule

// File: rtl/dice_eval.sv
module dice_eval
    import dice_pkg::*;
#(
    parameter int unsigned DIE_W = 3,
    parameter int unsigned SUM_W = DIE_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIE_W-1:0] die_a,
    input  logic [DIE_W-1:0] die_b,
    input  logic             save_point,
    output roll_flags_t      flags
);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] point_q;

    assign sum = SUM_W'(die_a) + SUM_W'(die_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            point_q <= '0;
        end else if (save_point) begin
            point_q <= sum;
        end
    end

    always_comb begin
        flags.sum7    = (int'(sum) == SUM_SEVEN);
        flags.natural = is_natural(int'(sum));
        flags.craps   = is_craps(int'(sum));
        flags.match   = (sum == point_q);
    end
endmodule

// File: rtl/dice_ctrl.sv
module dice_ctrl
    import dice_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        roll_btn,
    input  roll_flags_t flags,
    output ctrl_out_t   ctl
);
    game_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_FIRST_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FIRST_WAIT: if (roll_btn)  st_d = ST_FIRST_ROLL;
            ST_FIRST_ROLL: if (!roll_btn) st_d = ST_FIRST_EVAL;
            ST_FIRST_EVAL: begin
                if (flags.natural)    st_d = ST_WON;
                else if (flags.craps) st_d = ST_LOST;
                else                  st_d = ST_NEXT_WAIT;
            end
            ST_NEXT_WAIT:  if (roll_btn)  st_d = ST_NEXT_ROLL;
            ST_NEXT_ROLL:  if (!roll_btn) st_d = ST_NEXT_EVAL;
            ST_NEXT_EVAL: begin
                if (flags.match)     st_d = ST_WON;
                else if (flags.sum7) st_d = ST_LOST;
                else                 st_d = ST_NEXT_WAIT;
            end
            ST_WON:  st_d = ST_WON;
            ST_LOST: st_d = ST_LOST;
            default: st_d = ST_FIRST_WAIT;
        endcase
    end

    always_comb begin
        ctl.roll       = (st_q == ST_FIRST_ROLL) || (st_q == ST_NEXT_ROLL);
        ctl.save_point = (st_q == ST_FIRST_EVAL) && !flags.natural && !flags.craps;
        ctl.win        = (st_q == ST_WON);
        ctl.lose       = (st_q == ST_LOST);
    end
endmodule

// File: rtl/dice_game.sv
module dice_game
    import dice_pkg::*;
#(
    parameter int unsigned FACES = 6,
    parameter int unsigned DIE_W = $clog2(FACES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll_btn,
    output logic [DIE_W-1:0] die_a,
    output logic [DIE_W-1:0] die_b,
    output logic             win_led,
    output logic             lose_led
);
    localparam int unsigned SUM_W = DIE_W + 1;

    roll_flags_t flags;
    ctrl_out_t   ctl;
    logic        roll_en;
    logic        save_pt;

    assign roll_en = ctl.roll;
    assign save_pt = ctl.save_point;

    dice_pair #(.FACES(FACES), .DIE_W(DIE_W), .NUM_DICE(2)) pair_i (
        .clk   (clk),
        .rst   (rst),
        .roll  (roll_en),
        .die_a (die_a),
        .die_b (die_b)
    );

    dice_eval #(.DIE_W(DIE_W), .SUM_W(SUM_W)) eval_i (
        .clk        (clk),
        .rst        (rst),
        .die_a      (die_a),
        .die_b      (die_b),
        .save_point (save_pt),
        .flags      (flags)
    );

    dice_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .roll_btn (roll_btn),
        .flags    (flags),
        .ctl      (ctl)
    );

    assign win_led  = ctl.win;
    assign lose_led = ctl.lose;
endmodule

// File: rtl/dice_game_chk.sv
module dice_game_chk #(
    parameter int unsigned FACES = 6,
    parameter int unsigned DIE_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             roll_en,
    input logic             save_pt,
    input logic [DIE_W-1:0] die_a,
    input logic [DIE_W-1:0] die_b,
    input logic             win_led,
    input logic             lose_led
);
    localparam logic [DIE_W-1:0] TOP = DIE_W'(FACES);
    localparam logic [DIE_W-1:0] ONE = DIE_W'(1);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (die_a == ONE && die_b == ONE && !win_led && !lose_led));

    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        (die_a >= ONE && die_a <= TOP && die_b >= ONE && die_b <= TOP));

    p_step_a_r2: assert property (@(posedge clk) disable iff (rst)
        roll_en |=> die_a == (($past(die_a) == TOP) ? ONE : $past(die_a) + ONE));

    p_carry_b_r2: assert property (@(posedge clk) disable iff (rst)
        (roll_en && die_a == TOP) |=> die_b == (($past(die_b) == TOP) ? ONE : $past(die_b) + ONE));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !roll_en |=> ($stable(die_a) && $stable(die_b)));

    p_point_dark_r5: assert property (@(posedge clk) disable iff (rst)
        save_pt |-> (!win_led && !lose_led));

    p_held_dark_r9: assert property (@(posedge clk) disable iff (rst)
        roll_en |-> (!win_led && !lose_led));

    p_win_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        win_led |=> (win_led && !lose_led));

    p_lose_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        lose_led |=> (lose_led && !win_led));

    p_one_light_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({win_led, lose_led}) <= 1);
endmodule

bind dice_game dice_game_chk #(.FACES(FACES), .DIE_W(DIE_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .roll_en  (roll_en),
    .save_pt  (save_pt),
    .die_a    (die_a),
    .die_b    (die_b),
    .win_led  (win_led),
    .lose_led (lose_led)
);

// File: tb/dice_game_tb_top.sv
module dice_game_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FACES = 6;
    localparam int STATES = FACES * FACES;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       roll_btn = 1'b0;
    logic [2:0] die_a, die_b;
    logic       win_led, lose_led;

    int checks = 0;
    int fails  = 0;
    int idx    = 0;   // model position in the 36-state dice sequence

    always #2.5 clk = ~clk;

    dice_game dut_i (
        .clk      (clk),
        .rst      (rst),
        .roll_btn (roll_btn),
        .die_a    (die_a),
        .die_b    (die_b),
        .win_led  (win_led),
        .lose_led (lose_led)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int face_a(input int i);
        return (i % FACES) + 1;
    endfunction

    function automatic int face_b(input int i);
        return (i / FACES) + 1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idx = 0;
    endtask

    // Hold for n sampled edges, release, let judgement settle
    task automatic press(input int n);
        @(negedge clk);
        roll_btn = 1'b1;
        repeat (n) @(negedge clk);
        roll_btn = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_dice(input string req);
        chk(req, "die_a", int'(die_a), face_a(idx));
        chk(req, "die_b", int'(die_b), face_b(idx));
    endtask

    task automatic chk_lights(input string req, input int w, input int l);
        chk(req, "win_led", int'(win_led), w);
        chk(req, "lose_led", int'(lose_led), l);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int sum, point, sa, sb;
        bit done;

        // Full sweep of first-throw outcomes
        for (int t = 1; t <= STATES; t++) begin
            do_reset();
            chk_dice("R1");
            chk_lights("R1", 0, 0);
            press(t);
            idx = (idx + t) % STATES;
            chk_dice("R2");
            sum = face_a(idx) + face_b(idx);
            if (sum == 7 || sum == 11) begin
                chk_lights("R3", 1, 0);
            end else if (sum == 2 || sum == 3 || sum == 12) begin
                chk_lights("R4", 0, 1);
            end else begin
                chk_lights("R5", 0, 0);
                point = sum;
                done = 1'b0;
                for (int k = 0; k < 40 && !done; k++) begin
                    press(5);
                    idx = (idx + 5) % STATES;
                    chk_dice("R2");
                    sum = face_a(idx) + face_b(idx);
                    if (sum == point) begin
                        chk_lights("R6", 1, 0);
                        done = 1'b1;
                    end else if (sum == 7) begin
                        chk_lights("R7", 0, 1);
                        done = 1'b1;
                    end else begin
                        chk_lights("R8", 0, 0);
                    end
                end
            end
            // After a decision, presses are ignored
            sa = int'(die_a);
            sb = int'(die_b);
            sum = int'(win_led) * 2 + int'(lose_led);
            press(4);
            chk("R10", "die_a held", int'(die_a), sa);
            chk("R10", "die_b held", int'(die_b), sb);
            chk("R10", "lights held", int'(win_led) * 2 + int'(lose_led), sum);
        end

        // Lights stay dark while the button is still held
        do_reset();
        @(negedge clk);
        roll_btn = 1'b1;
        repeat (10) @(negedge clk);
        chk_lights("R9", 0, 0);
        chk("R9", "die_a mid-hold", int'(die_a), face_a(9));
        repeat (20) @(negedge clk);
        chk_lights("R9", 0, 0);
        roll_btn = 1'b0;
        repeat (3) @(negedge clk);
        idx = 30;
        chk_dice("R2");

        // Reset mid-game: a seven after reset must win, not lose
        do_reset();
        press(2);            // faces 3/1, sum 4 sets a point
        idx = 2;
        chk_lights("R5", 0, 0);
        do_reset();
        chk_dice("R11");
        press(5);            // faces 6/1, sum 7
        idx = 5;
        chk_dice("R11");
        chk_lights("R11", 1, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule